// File: doc/BRIEF.md
# Right-Justified Time-Slotted Audio Serializer

This block sends a pair of PCM samples (left, then right) out on one serial data line, one bit per bit-clock period, framed by a word clock that is high for the left half-frame and low for the right half-frame. Each channel's word is right-justified in its half. Its least significant bit occupies the last bit-clock slot before the word clock changes, and the most significant bit goes first. A programmable offset moves the whole word earlier by a number of slots. An optional high-impedance mode releases the line in every slot that carries no data, so that several transmitters can share one data line, each in its own slots.

The bit clock and word clock come from an external master. They are sampled by the block's system clock `clk`, which must run at least twice as fast as the bit clock. A polarity input selects which bit-clock edge launches data. The receiver samples on the other edge. Word length, offset, polarity and tristate mode are quasi-static configuration inputs. Both sample words are captured when a frame begins. `HALF_SLOTS` fixes the number of bit-clock periods in each half-frame. An optional input synchronizer (`SYNC_STAGES`) is chosen at elaboration.

Top module: `rj_tdm_tx`

## Requirements
- R1: While `rst_n` is low, `sdout` and `sdout_oe` are 0. After reset, no sample bit is sent until the first launch edge that sees `wclk` risen. Slots before that follow the idle-slot rules of R8 and R9.
- R2: The launch edge is the falling edge of `bclk` when `bclk_inv`=0 and the rising edge when `bclk_inv`=1. Outputs change only in the `clk` cycle after a launch edge is seen, and hold their value between launch edges.
- R3: A frame starts at a launch edge where `wclk` has risen since the previous launch edge. `wclk` high marks the left half and low marks the right half. Slot 0 of a half is the launch edge where `wclk` changed, and each half has `HALF_SLOTS` slots.
- R4: `wlen` selects the word length n: 00 gives 16, 01 gives 20, 10 gives 24 and 11 gives 32 bits. The word is taken from bits n-1..0 of the sample input, and higher bits are ignored.
- R5: With offset 0, a half's word is sent MSB first in slots `HALF_SLOTS`-n to `HALF_SLOTS`-1, so the LSB sits in the last slot before the word-clock edge.
- R6: An offset of k moves the word k slots earlier: the MSB goes in slot `HALF_SLOTS`-n-k and the LSB in slot `HALF_SLOTS`-1-k.
- R7: When n+k exceeds `HALF_SLOTS`, that half carries no data bit. All its slots are idle.
- R8: With `tri_en`=1, every slot without a data bit has `sdout_oe`=0 and `sdout`=0. Every data slot has `sdout_oe`=1.
- R9: With `tri_en`=0, every slot without a data bit drives `sdout`=0 with `sdout_oe`=1.
- R10: Both sample inputs are captured at the launch edge that starts the frame. Changes to them later in the frame do not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples bclk and wclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the bus master |
| wclk | input | 1 | Word clock: high for left half, low for right half |
| left_in | input | WORD_W | Left sample, right-aligned in the word |
| right_in | input | WORD_W | Right sample, right-aligned in the word |
| wlen | input | 2 | Word length code (16/20/24/32) |
| offset | input | OFF_W | Slots by which the word is moved earlier |
| bclk_inv | input | 1 | 0: launch on falling bclk, 1: launch on rising bclk |
| tri_en | input | 1 | Release the line in slots without data |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for sdout |

## Verification
Frame-start capture and the first data bit fall on the same launch edge when a 32-bit word with offset 0 fills a whole half. It also happens when n+k equals `HALF_SLOTS`. In that case the MSB must come from the sample being captured in that very cycle, not from the previous frame's copy. The bench provokes this by changing both sample inputs every frame and, in some frames, again a few slots after the start. The scoreboard's expected bits are computed only from the values present at slot 0, under both bit-clock polarities. A stale or late capture shows up as a wrong MSB or as corrupted bits later in the same frame.

// File: rtl/rj_pkg.sv
package rj_pkg;

   localparam int MAX_WORD = 32;
   localparam int MIN_WORD = 16;

   function automatic int word_bits(input logic [1:0] code);
      case (code)
         2'b00:   return 16;
         2'b01:   return 20;
         2'b10:   return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/rj_sync.sv
module rj_sync #(
   parameter int W      = 2,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rj_slot_ctr.sv
module rj_slot_ctr #(
   parameter  int HALF_SLOTS = 32,
   localparam int SLOT_W     = $clog2(HALF_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              wclk,
   input  logic              inv,
   output logic              launch,
   output logic              frame_go,
   output logic              left_nx,
   output logic              live_nx,
   output logic [SLOT_W-1:0] slot_nx
);

   localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(HALF_SLOTS);

   logic              bclk_q;
   logic              wclk_q;
   logic              live_q;
   logic [SLOT_W-1:0] slot_q;
   logic              wedge;

   assign launch   = (bclk != bclk_q) && (bclk == inv);
   assign wedge    = (wclk != wclk_q);
   assign frame_go = wedge && wclk;
   assign left_nx  = wclk;
   assign live_nx  = live_q || frame_go;

   always_comb begin
      if (wedge)                 slot_nx = '0;
      else if (slot_q == SLOT_MAX) slot_nx = SLOT_MAX;
      else                       slot_nx = slot_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         wclk_q <= 1'b1;
         live_q <= 1'b0;
         slot_q <= SLOT_MAX;
      end else begin
         bclk_q <= bclk;
         if (launch) begin
            wclk_q <= wclk;
            live_q <= live_nx;
            slot_q <= slot_nx;
         end
      end
   end

endmodule

// File: rtl/rj_bit_sel.sv
module rj_bit_sel #(
   parameter  int HALF_SLOTS = 32,
   parameter  int WORD_W     = 32,
   parameter  int OFF_W      = 5,
   localparam int SLOT_W     = $clog2(HALF_SLOTS + 1),
   localparam int IDX_W      = $clog2(WORD_W)
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic [1:0]        wlen,
   input  logic [OFF_W-1:0]  offset,
   input  logic [WORD_W-1:0] word,
   output logic              in_win,
   output logic              bit_o
);

   int               n;
   int               span;
   int               first;
   logic [IDX_W-1:0] idx;

   always_comb begin
      n      = rj_pkg::word_bits(wlen);
      span   = n + int'(offset);
      first  = HALF_SLOTS - span;
      in_win = 1'b0;
      idx    = '0;
      if (span <= HALF_SLOTS) begin
         if (int'(slot) >= first && int'(slot) < first + n) begin
            in_win = 1'b1;
            idx    = IDX_W'(first + n - 1 - int'(slot));
         end
      end
      bit_o = in_win & word[idx];
   end

endmodule

// File: rtl/rj_tdm_tx.sv
module rj_tdm_tx #(
   parameter int HALF_SLOTS  = 32,
   parameter int WORD_W      = 32,
   parameter int OFF_W       = 5,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              wclk,
   input  logic [WORD_W-1:0] left_in,
   input  logic [WORD_W-1:0] right_in,
   input  logic [1:0]        wlen,
   input  logic [OFF_W-1:0]  offset,
   input  logic              bclk_inv,
   input  logic              tri_en,
   output logic              sdout,
   output logic              sdout_oe
);

   localparam int SLOT_W = $clog2(HALF_SLOTS + 1);

   generate
      if (HALF_SLOTS < rj_pkg::MIN_WORD) begin : g_bad_half
         $error("HALF_SLOTS must hold at least the shortest word");
      end
      if (WORD_W < rj_pkg::MAX_WORD) begin : g_bad_word
         $error("WORD_W must hold the longest word");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES cannot be negative");
      end
   endgenerate

   logic              bclk_s, wclk_s;
   logic              launch, frame_go, left_nx, live_nx;
   logic [SLOT_W-1:0] slot_nx;
   logic [WORD_W-1:0] l_q, r_q, word_cur;
   logic              in_win, bit_cur, drive;

   rj_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bclk, wclk}),
      .q     ({bclk_s, wclk_s})
   );

   rj_slot_ctr #(.HALF_SLOTS(HALF_SLOTS)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk     (bclk_s),
      .wclk     (wclk_s),
      .inv      (bclk_inv),
      .launch   (launch),
      .frame_go (frame_go),
      .left_nx  (left_nx),
      .live_nx  (live_nx),
      .slot_nx  (slot_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_q <= '0;
         r_q <= '0;
      end else if (launch && frame_go) begin
         l_q <= left_in;
         r_q <= right_in;
      end
   end

   always_comb begin
      if (frame_go)     word_cur = left_in;
      else if (left_nx) word_cur = l_q;
      else              word_cur = r_q;
   end

   rj_bit_sel #(.HALF_SLOTS(HALF_SLOTS), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_sel (
      .slot   (slot_nx),
      .wlen   (wlen),
      .offset (offset),
      .word   (word_cur),
      .in_win (in_win),
      .bit_o  (bit_cur)
   );

   assign drive = in_win && live_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdout    <= 1'b0;
         sdout_oe <= 1'b0;
      end else if (launch) begin
         sdout    <= drive & bit_cur;
         sdout_oe <= drive | ~tri_en;
      end
   end

endmodule

// File: rtl/rj_tdm_tx_chk.sv
module rj_tdm_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic launch,
   input logic drive,
   input logic tri_en,
   input logic sdout,
   input logic sdout_oe
);

   // R1: reset clears both outputs
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!sdout && !sdout_oe));

   // R2: outputs move only after a launch edge
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> ($stable(sdout) && $stable(sdout_oe)));

   // R8: idle slot is released when tristating
   p_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !drive && tri_en) |=> (!sdout_oe && !sdout));

   // R8: a data slot always enables the line
   p_data_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && drive) |=> sdout_oe);

   // R9: idle slot drives zero when not tristating
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !drive && !tri_en) |=> (sdout_oe && !sdout));

endmodule

bind rj_tdm_tx rj_tdm_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .launch   (launch),
   .drive    (drive),
   .tri_en   (tri_en),
   .sdout    (sdout),
   .sdout_oe (sdout_oe)
);

// File: tb/sim_rj_tdm_tx.sv
module sim_rj_tdm_tx;

   localparam int HALF = 32;
   localparam int BH   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        wclk = 1'b0;
   logic [31:0] left_in = '0;
   logic [31:0] right_in = '0;
   logic [1:0]  wlen = 2'b00;
   logic [4:0]  offset = '0;
   logic        bclk_inv = 1'b0;
   logic        tri_en = 1'b1;
   wire         sdout;
   wire         sdout_oe;

   always #5 clk = ~clk;

   rj_tdm_tx u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk     (bclk),
      .wclk     (wclk),
      .left_in  (left_in),
      .right_in (right_in),
      .wlen     (wlen),
      .offset   (offset),
      .bclk_inv (bclk_inv),
      .tri_en   (tri_en),
      .sdout    (sdout),
      .sdout_oe (sdout_oe)
   );

   typedef struct {
      logic  sd;
      logic  oe;
      string tag;
      int    slot;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 0;
   event samp_ev;

   function automatic int nbits(input logic [1:0] c);
      case (c)
         2'b00:   return 16;
         2'b01:   return 20;
         2'b10:   return 24;
         default: return 32;
      endcase
   endfunction

   // monitor: pops one expectation per sampling edge
   initial begin
      forever begin
         @(samp_ev);
         total++;
         if (q.size() == 0) begin
            bad++;
            $display("FAIL R2 no expectation queued: sd=%b oe=%b expected none", sdout, sdout_oe);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (sdout !== e.sd || sdout_oe !== e.oe) begin
               bad++;
               $display("FAIL %s slot %0d: sd=%b oe=%b expected sd=%b oe=%b",
                        e.tag, e.slot, sdout, sdout_oe, e.sd, e.oe);
            end
         end
      end
   end

   // driver: one bit-clock period, launch edge then sampling edge
   task automatic slot(input logic w, input logic esd, input logic eoe,
                       input string tag, input int s);
      @(negedge clk);
      bclk = bclk_inv;
      wclk = w;
      q.push_back('{esd, eoe, tag, s});
      repeat (BH) @(negedge clk);
      ->samp_ev;
      bclk = ~bclk_inv;
      repeat (BH - 1) @(negedge clk);
   endtask

   task automatic half(input logic w, input logic live, input logic [31:0] word,
                       input int n, input int k, input string tag, input bit mid);
      for (int s = 0; s < HALF; s++) begin
         logic esd;
         logic eoe;
         int   first;
         bit   inw;
         esd   = 1'b0;
         inw   = 1'b0;
         first = HALF - n - k;
         if (live && (n + k <= HALF) && s >= first && s < first + n) begin
            inw = 1'b1;
            esd = word[first + n - 1 - s];
         end
         eoe = inw | ~tri_en;
         slot(w, esd, eoe, tag, s);
         if (mid && s == 2) begin
            left_in  = ~left_in;   // R10: late change must not reach the line
            right_in = right_in ^ 32'h5A5A_A5A5;
         end
      end
   endtask

   task automatic frame(input logic [31:0] l, input logic [31:0] r,
                        input logic [1:0] code, input int k, input string tag,
                        input bit mid);
      left_in  = l;
      right_in = r;
      wlen     = code;
      offset   = 5'(k);
      half(1'b1, 1'b1, l, nbits(code), k, {tag, " R3 left"}, mid);
      half(1'b0, 1'b1, r, nbits(code), k, {tag, " R3 right"}, 1'b0);
   endtask

   task automatic restart(input logic inv, input logic t);
      @(negedge clk);
      rst_n    = 1'b0;
      bclk_inv = inv;
      tri_en   = t;
      bclk     = ~inv;
      wclk     = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (sdout !== 1'b0 || sdout_oe !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset state: sd=%b oe=%b expected sd=0 oe=0", sdout, sdout_oe);
      end
      rst_n = 1'b1;
      repeat (BH) @(negedge clk);
      half(1'b0, 1'b0, 32'hFFFF_FFFF, 16, 0, "R1 before first frame", 1'b0);
   endtask

   initial begin
      restart(1'b0, 1'b1);
      // R4 R5 R8: short words, tristated idle slots, junk above bit n-1
      frame(32'hDEAD_9C35, 32'hBEEF_4A01, 2'b00, 0, "R4 R5 R8 wl16", 1'b0);
      frame(32'h000F_3A5C, 32'hFFF8_0003, 2'b01, 0, "R4 R5 R8 wl20", 1'b0);
      frame(32'h77C3_0FF1, 32'h0012_3456, 2'b10, 3, "R6 R8 wl24 off3", 1'b0);
      // R9 R10: full-width word fills the half, capture and MSB coincide
      tri_en = 1'b0;
      frame(32'h8000_0001, 32'hC3A5_5A3C, 2'b11, 0, "R5 R9 R10 wl32 full", 1'b1);
      frame(32'h1357_9BDF, 32'h2468_ACE0, 2'b01, 12, "R6 R9 wl20 off12 edge", 1'b1);
      frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, 9, "R7 R9 wl24 off9 overflow", 1'b0);
      tri_en = 1'b1;
      frame(32'hFFFF_FFFF, 32'hAAAA_AAAA, 2'b11, 1, "R7 R8 wl32 off1 overflow", 1'b0);
      // R2: inverted bit-clock polarity
      restart(1'b1, 1'b1);
      frame(32'h0000_B00B, 32'h0000_6DB6, 2'b00, 5, "R2 R6 R8 inverted wl16 off5", 1'b0);
      tri_en = 1'b0;
      frame(32'hF00D_CAFE, 32'h0BAD_F00D, 2'b11, 0, "R2 R10 inverted wl32", 1'b1);
      frame(32'h0055_AA33, 32'h00CC_3355, 2'b10, 0, "R2 R4 R5 inverted wl24", 1'b0);
      repeat (8) @(negedge clk);
      total++;
      if (q.size() != 0) begin
         bad++;
         $display("FAIL R3 leftover expectations: %0d expected 0", q.size());
      end
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired: run did not end, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule